// File: doc/BRIEF.md
# Microcontroller Register Access Port

This block is the 8-bit slave port through which a local microcontroller reaches the control registers and the buffer memory of a storage controller. It takes a chip select, active-low read and write strobes, a 7-bit address and an 8-bit data bus. The data bus is split into an input, an output and an output enable, and the pad ring joins them into one bidirectional bus. Two strap inputs set the port up. The polarity strap sets the sense of chip select. The mode strap chooses between direct addressing, where the address pins name the register, and indirect addressing. In indirect mode the port shows only two locations, an address pointer and a data window, and address bit 0 selects between them.

Behind the port sit a register file of general-purpose bytes, a control byte that holds the active level of the interrupt pin, and a buffer-memory window. Any access that falls in the window is passed to an external arbiter as a request. The port holds its wait output low until the arbiter grants the request. Strobes are brought into the internal clock domain through a synchronizer. A write takes effect when its strobe is released.

Top module: `mcu_port`

## Requirements
- R1: `pol_strap`=1 makes `cs_pin` active low, and `pol_strap`=0 makes it active high. A strobe given while chip select is inactive changes no register and does not drive the bus.
- R2: `data_oe` is 1 exactly while chip select is active and `rd_n` is 0, and it is 0 at all other times.
- R3: In direct mode (`ind_strap`=0), releasing `wr_n` with chip select active stores `data_in` into the register at `addr`. A later read of that address returns the stored value.
- R4: In indirect mode (`ind_strap`=1), an access with `addr[0]`=0 reaches the 7-bit pointer. A write loads it from `data_in[6:0]`, and a read returns it with bit 7 at 0.
- R5: In indirect mode, an access with `addr[0]`=1 reaches the location the pointer names. After each such read or write the pointer advances by one, and it wraps from 0x7F to 0x00.
- R6: Bit 0 of the control byte at address 0x20 sets the interrupt level. When it is 1, `irq_pin` equals `irq_req`. When it is 0, `irq_pin` is the inverse of `irq_req`. A read of 0x20 returns the bit in position 0 and zeros above it.
- R7: Addresses 0x40–0x7F form the buffer window. An access there raises `buf_req` with `buf_addr` set to the low 6 address bits and `buf_we` set to 1 for a write, along with `buf_wdata`. `buf_req` stays high, and `wait_n` stays low, until `buf_grant` arrives. A read of the window returns the `buf_rdata` value captured at the grant.
- R8: Reset clears the register file, the pointer and the interrupt-level bit. After reset `wait_n` is 1, `buf_req` is 0, `data_oe` is 0 and `irq_pin` is the inverse of `irq_req`.
- R9: Registers 0x00–0x1F hold data. Addresses 0x21–0x3F read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pol_strap | input | 1 | Chip-select sense strap (1: active low) |
| ind_strap | input | 1 | Addressing-mode strap (1: indirect) |
| cs_pin | input | 1 | Chip select from the microcontroller |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, takes effect on release |
| addr | input | 7 | Register address; bit 0 selects pointer or data in indirect mode |
| data_in | input | 8 | Write data from the bus |
| data_out | output | 8 | Read data to the bus |
| data_oe | output | 1 | Bus drive enable |
| wait_n | output | 1 | Wait to the microcontroller, low while a buffer access is pending |
| irq_req | input | 1 | Interrupt request from the controller core |
| irq_pin | output | 1 | Interrupt output at the programmed level |
| buf_req | output | 1 | Buffer memory access request |
| buf_we | output | 1 | Request is a write |
| buf_addr | output | 6 | Offset within the buffer window |
| buf_wdata | output | 8 | Data for a buffer write |
| buf_rdata | input | 8 | Data returned with the grant |
| buf_grant | input | 1 | Arbiter grant, completes the pending request |

## Verification
The hardest cases to reach from the ports are the pointer wrap and the pointer steering a data-port access into the buffer window. Both need a pointer load, then an indirect data access that must wait out an arbiter grant. The stimulus loads the pointer with 0x7F and reads the data port, which raises a buffer request for offset 0x3F. A grant responder in the bench answers that request. The bench then reads the pointer back and expects 0x00. Indirect writes starting at 0x1F carry the pointer across the end of the register file onto the control byte.

// File: rtl/mcu_port_pkg.sv
package mcu_port_pkg;

  // Kind of location an effective address falls on
  typedef enum logic [1:0] {
    SP_REG  = 2'd0,
    SP_CTRL = 2'd1,
    SP_BUF  = 2'd2,
    SP_NONE = 2'd3
  } space_e;

  // Chip select is active when the pin differs from the polarity strap
  function automatic logic cs_decode(input logic pin, input logic strap);
    return pin ^ strap;
  endfunction

  // Interrupt pin level for a request and the programmed active level
  function automatic logic irq_level(input logic req, input logic act_high);
    return act_high ? req : ~req;
  endfunction

endpackage

// File: rtl/mcu_strobe_sync.sv
module mcu_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_prev
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], d};
  end

  assign q      = chain[STAGES-1];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/mcu_regfile.sv
module mcu_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       mem[i] <= '0;
      else if (we && widx == IW'(i))    mem[i] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/mcu_buf_bridge.sv
module mcu_buf_bridge #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_we,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  input  logic          grant,
  input  logic [DW-1:0] rdata,
  output logic          req,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] hold,
  output logic          busy
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      we     <= 1'b0;
      addr   <= '0;
      wdata  <= '0;
      hold   <= '0;
    end else if (pend_q) begin
      if (grant) begin
        pend_q <= 1'b0;
        if (!we) hold <= rdata;
      end
    end else if (start) begin
      pend_q <= 1'b1;
      we     <= start_we;
      addr   <= start_addr;
      wdata  <= start_wdata;
    end
  end

  assign req  = pend_q;
  assign busy = pend_q;
endmodule

// File: rtl/mcu_port.sv
module mcu_port #(
  parameter int          ADDR_W      = 7,
  parameter int          DATA_W      = 8,
  parameter int          NREG        = 32,
  parameter int          CTRL_ADDR   = 32,
  parameter int          SYNC_STAGES = 2,
  localparam int         BUF_AW      = ADDR_W - 1,
  localparam int         IDX_W       = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pol_strap,
  input  logic              ind_strap,
  input  logic              cs_pin,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              wait_n,
  input  logic              irq_req,
  output logic              irq_pin,
  output logic              buf_req,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_wdata,
  input  logic [DATA_W-1:0] buf_rdata,
  input  logic              buf_grant
);
  import mcu_port_pkg::*;

  // Classify an effective address
  function automatic space_e classify(input logic [ADDR_W-1:0] a);
    if (a[ADDR_W-1])                    return SP_BUF;
    else if (a < ADDR_W'(NREG))         return SP_REG;
    else if (a == ADDR_W'(CTRL_ADDR))   return SP_CTRL;
    else                                return SP_NONE;
  endfunction

  // Pointer advance, wrapping at the address width
  function automatic logic [ADDR_W-1:0] ptr_step(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(1);
  endfunction

  // Chip select as seen at the pins
  logic cs_act;
  assign cs_act = cs_decode(cs_pin, pol_strap);

  // Synchronized strobes
  logic cs_s, cs_d, rd_s, rd_d, wr_s, wr_d;

  mcu_strobe_sync #(.STAGES(SYNC_STAGES)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .d(cs_act), .q(cs_s), .q_prev(cs_d));
  mcu_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .d(~rd_n), .q(rd_s), .q_prev(rd_d));
  mcu_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .d(~wr_n), .q(wr_s), .q_prev(wr_d));

  // Named internal events
  logic rd_start, rd_end, wr_commit;
  assign rd_start  = cs_s & rd_s & ~rd_d;
  assign rd_end    = cs_d & rd_d & ~rd_s;
  assign wr_commit = cs_d & wr_d & ~wr_s;

  // Port decode
  logic ptr_port, data_port;
  assign ptr_port  = ind_strap & ~addr[0];
  assign data_port = ind_strap &  addr[0];

  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] eff;
  space_e            sp;
  assign eff = ind_strap ? ptr_q : addr;
  assign sp  = classify(eff);

  logic ptr_bump;
  assign ptr_bump = data_port & (rd_end | wr_commit);

  // Pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ptr_q <= '0;
    else if (wr_commit && ptr_port)  ptr_q <= data_in[ADDR_W-1:0];
    else if (ptr_bump)               ptr_q <= ptr_step(ptr_q);
  end

  // Interrupt active level
  logic irq_pol;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      irq_pol <= 1'b0;
    else if (wr_commit && !ptr_port && sp == SP_CTRL) irq_pol <= data_in[0];
  end
  assign irq_pin = irq_level(irq_req, irq_pol);

  // Register file
  logic              rf_we;
  logic [DATA_W-1:0] rf_rdata;
  assign rf_we = wr_commit & ~ptr_port & (sp == SP_REG);

  mcu_regfile #(.NREG(NREG), .DW(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we),
    .widx(eff[IDX_W-1:0]), .wdata(data_in),
    .ridx(eff[IDX_W-1:0]), .rdata(rf_rdata));

  // Buffer window bridge
  logic              buf_start, buf_busy;
  logic [DATA_W-1:0] buf_hold;
  assign buf_start = (wr_commit | rd_start) & ~ptr_port & (sp == SP_BUF);

  mcu_buf_bridge #(.AW(BUF_AW), .DW(DATA_W)) u_bridge (
    .clk(clk), .rst_n(rst_n),
    .start(buf_start), .start_we(wr_commit),
    .start_addr(eff[BUF_AW-1:0]), .start_wdata(data_in),
    .grant(buf_grant), .rdata(buf_rdata),
    .req(buf_req), .we(buf_we), .addr(buf_addr), .wdata(buf_wdata),
    .hold(buf_hold), .busy(buf_busy));

  assign wait_n = ~buf_busy;

  // Read path
  always_comb begin
    if (ptr_port) begin
      data_out = DATA_W'(ptr_q);
    end else begin
      unique case (sp)
        SP_REG:  data_out = rf_rdata;
        SP_CTRL: data_out = DATA_W'(irq_pol);
        SP_BUF:  data_out = buf_hold;
        default: data_out = '0;
      endcase
    end
  end

  assign data_oe = cs_act & ~rd_n;
endmodule

// File: rtl/mcu_port_chk.sv
module mcu_port_chk #(
  parameter int ADDR_W = 7,
  parameter int BUF_AW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pol_strap,
  input logic              cs_pin,
  input logic              rd_n,
  input logic              data_oe,
  input logic              wait_n,
  input logic              buf_req,
  input logic              buf_grant,
  input logic [BUF_AW-1:0] buf_addr,
  input logic              irq_req,
  input logic              irq_pin,
  input logic              irq_pol,
  input logic [ADDR_W-1:0] ptr_q,
  input logic              ptr_bump
);
  // R2
  oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !rd_n);

  // R1
  cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_pin == pol_strap) |-> !data_oe);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_req && !buf_grant) |=> buf_req);

  // R7
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_req && !buf_grant) |=> $stable(buf_addr));

  // R7
  wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_req && buf_grant) |=> wait_n);

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_bump |=> (ptr_q == ADDR_W'($past(ptr_q) + 1'b1)));

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(irq_pol) && (irq_req != $past(irq_req))) |-> (irq_pin != $past(irq_pin)));
endmodule

bind mcu_port mcu_port_chk #(.ADDR_W(ADDR_W), .BUF_AW(BUF_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pol_strap(pol_strap), .cs_pin(cs_pin),
  .rd_n(rd_n), .data_oe(data_oe), .wait_n(wait_n), .buf_req(buf_req),
  .buf_grant(buf_grant), .buf_addr(buf_addr), .irq_req(irq_req),
  .irq_pin(irq_pin), .irq_pol(irq_pol), .ptr_q(ptr_q), .ptr_bump(ptr_bump));

// File: tb/sim_mcu_port.sv
module sim_mcu_port;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       pol_strap = 1, ind_strap = 0;
  logic       cs_pin = 1, rd_n = 1, wr_n = 1;
  logic [6:0] addr = 0;
  logic [7:0] data_in = 0;
  logic [7:0] data_out;
  logic       data_oe, wait_n, irq_pin;
  logic       irq_req = 0;
  logic       buf_req, buf_we;
  logic [5:0] buf_addr;
  logic [7:0] buf_wdata;
  logic [7:0] buf_rdata = 0;
  logic       buf_grant = 0;

  always #10 clk = ~clk;

  mcu_port u0 (
    .clk(clk), .rst_n(rst_n), .pol_strap(pol_strap), .ind_strap(ind_strap),
    .cs_pin(cs_pin), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .wait_n(wait_n),
    .irq_req(irq_req), .irq_pin(irq_pin), .buf_req(buf_req), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .buf_grant(buf_grant));

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model
  logic [7:0] mregs [0:127];
  logic [7:0] bmem  [0:63];
  int         mptr = 0;
  bit         mpol = 0;
  bit         wr_busy = 0;
  bit         mon_en = 0;

  // Grant responder observations
  bit         saw_wait_low = 0;
  int         last_baddr = -1;
  bit         last_bwe = 0;
  logic [7:0] last_bwdata = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [6:0] a);
    int e;
    if (ind_strap && !a[0]) return 8'(mptr);
    e = ind_strap ? mptr : int'(a);
    if (e < 32)       return mregs[e];
    else if (e == 32) return {7'b0, mpol};
    else if (e >= 64) return bmem[e - 64];
    else              return 8'h00;
  endfunction

  function automatic bit cs_level(input bit active);
    return active ? ~pol_strap : pol_strap;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 128; i++) mregs[i] = 8'h00;
    mptr = 0;
    mpol = 0;
  endtask

  task automatic do_reset(input bit pol, input bit ind);
    @(negedge clk);
    mon_en = 0;
    rst_n = 0;
    pol_strap = pol;
    ind_strap = ind;
    cs_pin = pol;
    rd_n = 1;
    wr_n = 1;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 wait_n after reset", wait_n, 1);
    chk("R8 buf_req after reset", buf_req, 0);
    chk("R8 data_oe after reset", data_oe, 0);
    chk("R8 irq_pin after reset", irq_pin, !irq_req);
    mon_en = 1;
  endtask

  task automatic mcu_write(input logic [6:0] a, input logic [7:0] d, input bit en);
    int e;
    @(negedge clk);
    wr_busy = 1;
    addr = a;
    data_in = d;
    cs_pin = cs_level(en);
    repeat (2) @(negedge clk);
    wr_n = 0;
    repeat (4) @(negedge clk);
    wr_n = 1;
    repeat (4) @(negedge clk);
    while (!wait_n) @(negedge clk);
    @(negedge clk);
    if (en) begin
      if (ind_strap && !a[0]) mptr = int'(d[6:0]);
      else begin
        e = ind_strap ? mptr : int'(a);
        if (e < 32)       mregs[e] = d;
        else if (e == 32) mpol = d[0];
        if (ind_strap) mptr = (mptr + 1) % 128;
      end
    end
    cs_pin = cs_level(0);
    repeat (2) @(negedge clk);
    wr_busy = 0;
  endtask

  task automatic mcu_read(input string req, input logic [6:0] a, input bit en);
    logic [7:0] exp;
    @(negedge clk);
    addr = a;
    cs_pin = cs_level(en);
    repeat (2) @(negedge clk);
    rd_n = 0;
    repeat (4) @(negedge clk);
    while (!wait_n) @(negedge clk);
    repeat (2) @(negedge clk);
    chk({req, " oe"}, data_oe, en);
    if (en) begin
      exp = exp_read(a);
      chk({req, " data"}, data_out, exp);
    end
    rd_n = 1;
    repeat (4) @(negedge clk);
    if (en && ind_strap && a[0]) mptr = (mptr + 1) % 128;
    cs_pin = cs_level(0);
    repeat (2) @(negedge clk);
  endtask

  // External buffer arbiter and memory
  initial begin
    int gcnt = 0;
    for (int i = 0; i < 64; i++) bmem[i] = 8'(i * 7 + 3);
    forever begin
      @(negedge clk);
      if (!wait_n) saw_wait_low = 1;
      if (buf_grant) buf_grant = 0;
      else if (buf_req) begin
        if (gcnt == 2) begin
          gcnt = 0;
          last_baddr = int'(buf_addr);
          last_bwe = buf_we;
          last_bwdata = buf_wdata;
          if (buf_we) bmem[buf_addr] = buf_wdata;
          else buf_rdata = bmem[buf_addr];
          buf_grant = 1;
        end else gcnt++;
      end
    end
  end

  // Per-clock comparison against the model
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n && mon_en) begin
        chk("R2 oe per clock", data_oe, (cs_pin ^ pol_strap) && !rd_n);
        chk("R7 wait vs req", wait_n, !buf_req);
        if (!wr_busy) chk("R6 irq level", irq_pin, mpol ? irq_req : !irq_req);
      end
    end
  end

  // Watchdog
  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    // Phase 1: active-low chip select, direct mode
    do_reset(1, 0);
    mcu_write(7'h05, 8'hA5, 1);
    mcu_write(7'h1F, 8'h3C, 1);
    mcu_read("R3 reg05", 7'h05, 1);
    mcu_read("R3 reg1F", 7'h1F, 1);
    mcu_write(7'h06, 8'h99, 0);
    mcu_read("R1 inactive write ignored", 7'h06, 1);
    mcu_read("R1 inactive read", 7'h05, 0);
    mcu_write(7'h25, 8'hFF, 1);
    mcu_read("R9 unmapped", 7'h25, 1);
    mcu_write(7'h20, 8'h01, 1);
    mcu_read("R6 ctrl readback", 7'h20, 1);
    @(negedge clk) irq_req = 1;
    @(negedge clk) chk("R6 active high irq", irq_pin, 1);
    @(negedge clk) irq_req = 0;
    @(negedge clk) chk("R6 active high idle", irq_pin, 0);
    // Buffer window
    saw_wait_low = 0;
    mcu_write(7'h45, 8'h77, 1);
    chk("R7 write addr", last_baddr, 5);
    chk("R7 write we", last_bwe, 1);
    chk("R7 write data", last_bwdata, 8'h77);
    chk("R7 wait seen low", saw_wait_low, 1);
    mcu_read("R7 window read", 7'h45, 1);
    chk("R7 read we", last_bwe, 0);
    mcu_read("R7 window read other", 7'h7E, 1);
    chk("R7 read addr", last_baddr, 6'h3E);

    // Phase 2: active-high chip select; reset clears state
    do_reset(0, 0);
    mcu_read("R8 reg cleared", 7'h05, 1);
    mcu_read("R8 ctrl cleared", 7'h20, 1);
    mcu_write(7'h03, 8'h5A, 1);
    mcu_read("R1 active high access", 7'h03, 1);
    mcu_write(7'h04, 8'h11, 0);
    mcu_read("R1 active high inactive", 7'h04, 1);

    // Phase 3: indirect mode
    do_reset(1, 1);
    mcu_read("R8 ptr cleared", 7'h00, 1);
    mcu_write(7'h00, 8'h08, 1);
    mcu_read("R4 ptr readback", 7'h00, 1);
    mcu_write(7'h01, 8'h11, 1);
    mcu_write(7'h01, 8'h22, 1);
    mcu_write(7'h01, 8'h33, 1);
    mcu_read("R5 ptr after burst", 7'h00, 1);
    mcu_write(7'h00, 8'h08, 1);
    mcu_read("R5 burst read 8", 7'h01, 1);
    mcu_read("R5 burst read 9", 7'h01, 1);
    mcu_read("R5 burst read 10", 7'h01, 1);
    mcu_write(7'h00, 8'h1F, 1);
    mcu_write(7'h01, 8'hC3, 1);
    mcu_write(7'h01, 8'h01, 1);
    mcu_read("R5 ptr crossed", 7'h00, 1);
    @(negedge clk) irq_req = 1;
    @(negedge clk) chk("R6 indirect ctrl write", irq_pin, 1);
    @(negedge clk) irq_req = 0;
    mcu_write(7'h00, 8'h7F, 1);
    mcu_read("R5 window via ptr", 7'h01, 1);
    chk("R7 ptr window addr", last_baddr, 6'h3F);
    mcu_read("R5 ptr wrap", 7'h00, 1);
    mcu_write(7'h00, 8'h2A, 1);
    mcu_write(7'h01, 8'hEE, 1);
    mcu_read("R9 indirect unmapped ptr", 7'h00, 1);
    mcu_write(7'h00, 8'h2A, 1);
    mcu_read("R9 indirect unmapped read", 7'h01, 1);

    repeat (5) @(negedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule